// File: doc/BRIEF.md
# Flash Completion Poller

This block sits on the host side of a parallel flash interface. Once software has finished writing a program or erase command sequence, it starts the poller. The poller then reads the device status byte at one address, again and again, until the operation has finished or a read budget runs out. The caller supplies the operation kind, the byte that was programmed, and the poll address. For a program this is the programmed location. For an erase it must lie inside a sector that is being erased, never in a protected sector.

Completion can be detected in two ways:
- **Flag mode:** bit 7 is compared against the expected value.
- **Toggle mode:** bit 6 of two consecutive reads is compared.

A completion seen once is not taken as final, because the low bits of the byte may still be settling. The poller issues a further confirming read, and the byte from that read becomes the result. For a program, that byte is also compared with the intended data.

Top module: `flash_poll_ctrl`

## Requirements
- R1: While rst_ni is low and after its release, busy_o, done_o, timeout_o, error_o and rd_req_o are 0 and data_o is all zeros.
- R2: start_i is accepted only when busy_o is 0. When it is accepted, op_erase_i (1 = erase, 0 = program), mode_toggle_i (1 = toggle mode, 0 = flag mode), exp_data_i, poll_addr_i and max_polls_i are latched, and busy_o rises on the next cycle. A start_i while busy_o is 1 changes nothing. rd_req_o is never high while busy_o is 0.
- R3: No read request is made during the START_GAP clock cycles that follow the accepting edge, so that polling begins only after the final write pulse has settled.
- R4: Only one read is outstanding at a time. rd_req_o stays high until rd_ack_i is sampled high, and rd_addr_o equals the latched poll address throughout.
- R5: In flag mode for a program, a read counts as complete when its bit 7 equals bit 7 of the expected byte.
- R6: In flag mode for an erase, a read counts as complete when its bit 7 is 1.
- R7: In toggle mode, a read counts as complete when its bit 6 equals bit 6 of the read just before it in the same operation. The first read of an operation never counts as complete.
- R8: After a complete poll read, one confirming read is issued and judged by the same rule. If it is complete, done_o rises and data_o holds the confirming byte. If it is not, polling resumes.
- R9: Every read counts toward the budget. After a read that is not complete, if the number of reads so far is at least max_polls_i, timeout_o rises and no further reads are issued.
- R10: error_o is 1 at completion exactly when the operation is a program and data_o differs from exp_data_i. error_o is never set for an erase.
- R11: done_o, timeout_o and error_o hold until the next accepted start. done_o and timeout_o are never both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin polling (single-cycle pulse) |
| op_erase_i | input | 1 | 1 = erase, 0 = program |
| mode_toggle_i | input | 1 | 1 = bit-6 toggle compare, 0 = bit-7 flag check |
| exp_data_i | input | DATA_W | Byte written by the program |
| poll_addr_i | input | ADDR_W | Address to poll |
| max_polls_i | input | CNT_W | Read budget |
| rd_req_o | output | 1 | Read request |
| rd_addr_o | output | ADDR_W | Read address |
| rd_data_i | input | DATA_W | Read data, valid with rd_ack_i |
| rd_ack_i | input | 1 | Read acknowledge |
| busy_o | output | 1 | Operation in progress |
| done_o | output | 1 | Completion confirmed |
| timeout_o | output | 1 | Budget exhausted |
| error_o | output | 1 | Program result mismatch |
| data_o | output | DATA_W | Confirmed final byte |

## Verification
The bench targets four failure modes:
- **Transient read:** a status read just before the end carries the final bit 7 but wrong low bits. A poller that skipped the confirming read would report those wrong bits in data_o.
- **Accidental toggle match:** a toggle read whose bit 6 happens to match the previous read sends the poller into a confirm that fails. A design that did not resume polling would stall or finish with the wrong byte.
- **Budget boundary:** cases are placed where completion lands exactly at the budget limit, and where max_polls_i is zero. An off-by-one counter would time out early or issue an extra read.
- **Overlapping start:** a second start during a run tries to change the poll address. It must not.

Random acknowledge latency exercises R4.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;
  localparam int unsigned FLAG_BIT = 7;
  localparam int unsigned TOG_BIT  = 6;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT,
    ST_RD_POLL,
    ST_EV_POLL,
    ST_RD_CONF,
    ST_EV_CONF,
    ST_DONE,
    ST_TMO
  } poll_state_e;
endpackage

// File: rtl/poll_start_delay.sv
module poll_start_delay #(
  parameter int unsigned GAP = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic load_i,
  input  logic run_i,
  output logic expired_o
);
  localparam int unsigned W = $clog2(GAP + 2);
  localparam logic [W-1:0] GAP_V = W'(GAP);

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                  cnt_q <= '0;
    else if (load_i)              cnt_q <= GAP_V;
    else if (run_i && cnt_q != 0) cnt_q <= cnt_q - 1'b1;
  end

  assign expired_o = (cnt_q == '0);

  AST_GAP_NO_JUMP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!load_i && !expired_o) |=> (cnt_q <= $past(cnt_q))) else $error("gap counter grew"); // R3
endmodule

// File: rtl/poll_read_port.sv
module poll_read_port #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              clr_i,
  input  logic              en_i,
  input  logic              ack_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              req_o,
  output logic              got_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              prev_tog_o,
  output logic              prev_vld_o
);
  import flash_poll_pkg::*;

  logic [DATA_W-1:0] byte_q;
  logic              have_q, prev_vld_q, prev_tog_q;

  assign req_o = en_i;
  assign got_o = en_i && ack_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      byte_q     <= '0;
      have_q     <= 1'b0;
      prev_vld_q <= 1'b0;
      prev_tog_q <= 1'b0;
    end else if (clr_i) begin
      have_q     <= 1'b0;
      prev_vld_q <= 1'b0;
    end else if (got_o) begin
      byte_q     <= data_i;
      prev_tog_q <= byte_q[TOG_BIT];
      prev_vld_q <= have_q;
      have_q     <= 1'b1;
    end
  end

  assign byte_o     = byte_q;
  assign prev_tog_o = prev_tog_q;
  assign prev_vld_o = prev_vld_q;

  AST_REQ_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_o && !ack_i) |=> req_o) else $error("request dropped before ack"); // R4
endmodule

// File: rtl/poll_status_eval.sv
module poll_status_eval #(
  parameter int unsigned DATA_W = 8
) (
  input  logic [DATA_W-1:0] byte_i,
  input  logic [DATA_W-1:0] exp_i,
  input  logic              erase_i,
  input  logic              toggle_mode_i,
  input  logic              prev_tog_i,
  input  logic              prev_vld_i,
  output logic              complete_o
);
  import flash_poll_pkg::*;

  logic flag_ok, tog_ok;

  always_comb begin
    flag_ok    = erase_i ? byte_i[FLAG_BIT] : (byte_i[FLAG_BIT] == exp_i[FLAG_BIT]);
    tog_ok     = prev_vld_i && (byte_i[TOG_BIT] == prev_tog_i);
    complete_o = toggle_mode_i ? tog_ok : flag_ok;
  end
endmodule

// File: rtl/poll_limit_cnt.sv
module poll_limit_cnt #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             inc_i,
  input  logic [CNT_W-1:0] limit_i,
  output logic [CNT_W-1:0] count_o,
  output logic             reached_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                       cnt_q <= '0;
    else if (clr_i)                    cnt_q <= '0;
    else if (inc_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
  end

  assign count_o   = cnt_q;
  assign reached_o = (cnt_q >= limit_i);

  AST_CNT_NO_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clr_i && $past(!clr_i)) |-> (cnt_q >= $past(cnt_q))) else $error("read count wrapped"); // R9
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl #(
  parameter int unsigned DATA_W    = 8,
  parameter int unsigned ADDR_W    = 24,
  parameter int unsigned CNT_W     = 16,
  parameter int unsigned START_GAP = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  logic              op_erase_i,
  input  logic              mode_toggle_i,
  input  logic [DATA_W-1:0] exp_data_i,
  input  logic [ADDR_W-1:0] poll_addr_i,
  input  logic [CNT_W-1:0]  max_polls_i,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  input  logic [DATA_W-1:0] rd_data_i,
  input  logic              rd_ack_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              timeout_o,
  output logic              error_o,
  output logic [DATA_W-1:0] data_o
);
  import flash_poll_pkg::*;

  poll_state_e       state_q, state_d;
  logic              erase_q, toggle_q, err_q;
  logic [DATA_W-1:0] exp_q, data_q;
  logic [ADDR_W-1:0] addr_q;
  logic [CNT_W-1:0]  max_q;

  logic              accept, gap_done, rd_en, got;
  logic [DATA_W-1:0] rd_byte;
  logic              prev_tog, prev_vld, complete;
  logic [CNT_W-1:0]  rd_count;
  logic              at_limit;

  assign busy_o = !(state_q inside {ST_IDLE, ST_DONE, ST_TMO});
  assign accept = start_i && !busy_o;
  assign rd_en  = (state_q == ST_RD_POLL) || (state_q == ST_RD_CONF);

  poll_start_delay #(.GAP(START_GAP)) u_gap (
    .clk_i, .rst_ni,
    .load_i    (accept),
    .run_i     (state_q == ST_WAIT),
    .expired_o (gap_done)
  );

  poll_read_port #(.DATA_W(DATA_W)) u_rd (
    .clk_i, .rst_ni,
    .clr_i      (accept),
    .en_i       (rd_en),
    .ack_i      (rd_ack_i),
    .data_i     (rd_data_i),
    .req_o      (rd_req_o),
    .got_o      (got),
    .byte_o     (rd_byte),
    .prev_tog_o (prev_tog),
    .prev_vld_o (prev_vld)
  );

  poll_status_eval #(.DATA_W(DATA_W)) u_eval (
    .byte_i        (rd_byte),
    .exp_i         (exp_q),
    .erase_i       (erase_q),
    .toggle_mode_i (toggle_q),
    .prev_tog_i    (prev_tog),
    .prev_vld_i    (prev_vld),
    .complete_o    (complete)
  );

  poll_limit_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i, .rst_ni,
    .clr_i     (accept),
    .inc_i     (got),
    .limit_i   (max_q),
    .count_o   (rd_count),
    .reached_o (at_limit)
  );

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE, ST_DONE, ST_TMO: if (start_i) state_d = ST_WAIT;
      ST_WAIT:    if (gap_done) state_d = ST_RD_POLL;
      ST_RD_POLL: if (got)      state_d = ST_EV_POLL;
      ST_EV_POLL: state_d = complete ? ST_RD_CONF : (at_limit ? ST_TMO : ST_RD_POLL);
      ST_RD_CONF: if (got)      state_d = ST_EV_CONF;
      ST_EV_CONF: state_d = complete ? ST_DONE : (at_limit ? ST_TMO : ST_RD_POLL);
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      erase_q  <= 1'b0;
      toggle_q <= 1'b0;
      exp_q    <= '0;
      addr_q   <= '0;
      max_q    <= '0;
      data_q   <= '0;
      err_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        erase_q  <= op_erase_i;
        toggle_q <= mode_toggle_i;
        exp_q    <= exp_data_i;
        addr_q   <= poll_addr_i;
        max_q    <= max_polls_i;
        data_q   <= '0;
        err_q    <= 1'b0;
      end else if (state_q == ST_EV_CONF && complete) begin
        data_q <= rd_byte;
        err_q  <= !erase_q && (rd_byte != exp_q);
      end
    end
  end

  assign rd_addr_o = addr_q;
  assign done_o    = (state_q == ST_DONE);
  assign timeout_o = (state_q == ST_TMO);
  assign error_o   = err_q;
  assign data_o    = data_q;

  AST_NO_REQ_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> !rd_req_o) else $error("read while idle"); // R2
  AST_ADDR_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(rd_addr_o)) else $error("address moved"); // R4
  AST_TMO_AT_LIMIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(timeout_o) |-> (rd_count >= max_q)) else $error("early timeout"); // R9
  AST_ERR_WITH_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> done_o) else $error("error without done"); // R10
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(done_o && timeout_o)) else $error("done and timeout together"); // R11
  AST_DONE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !start_i) |=> done_o) else $error("done dropped"); // R11
endmodule

// File: tb/flash_poll_ctrl_tb_top.sv
module flash_poll_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int GAP = 4;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        start_i = 1'b0, op_erase_i = 1'b0, mode_toggle_i = 1'b0;
  logic [7:0]  exp_data_i = '0;
  logic [23:0] poll_addr_i = '0;
  logic [15:0] max_polls_i = '0;
  logic        rd_req_o;
  logic [23:0] rd_addr_o;
  logic [7:0]  rd_data_i;
  logic        rd_ack_i;
  logic        busy_o, done_o, timeout_o, error_o;
  logic [7:0]  data_o;

  flash_poll_ctrl #(.START_GAP(GAP)) dut_i (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int n_chk = 0, n_fail = 0;
  int cyc = 0;
  logic [7:0]  seq [64];
  int          idx = 0, first_cyc = -1, addr_bad = 0, req_drop = 0, lat_max = 0;
  logic [23:0] cur_addr = '0;

  always @(posedge clk_i) cyc <= cyc + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // read responder
  initial begin
    rd_ack_i = 1'b0;
    rd_data_i = '0;
    forever begin
      @(negedge clk_i);
      rd_ack_i = 1'b0;
      if (rd_req_o) begin
        if (idx == 0) first_cyc = cyc;
        if (rd_addr_o != cur_addr) addr_bad++;
        repeat ($urandom_range(0, lat_max)) begin
          @(negedge clk_i);
          if (!rd_req_o) req_drop++;
          if (rd_addr_o != cur_addr) addr_bad++;
        end
        rd_data_i = seq[idx < 64 ? idx : 63];
        idx++;
        rd_ack_i = 1'b1;
      end
    end
  end

  function automatic bit is_cpl(input bit er, input bit md, input logic [7:0] e,
                                input logic [7:0] b, input bit pv, input bit p6);
    if (md) return pv && (b[6] == p6);
    return er ? b[7] : (b[7] == e[7]);
  endfunction

  function automatic void predict(input bit er, input bit md, input logic [7:0] e, input int mx,
                                  output bit dn, output bit err, output logic [7:0] dat,
                                  output int nrd);
    bit pv = 0, p6 = 0, m;
    logic [7:0] b;
    nrd = 0; dn = 0; err = 0; dat = '0;
    while (nrd < 62) begin
      b = seq[nrd]; nrd++;
      m = is_cpl(er, md, e, b, pv, p6); pv = 1; p6 = b[6];
      if (m) begin
        b = seq[nrd]; nrd++;
        m = is_cpl(er, md, e, b, pv, p6); p6 = b[6];
        if (m) begin
          dn = 1; dat = b; err = !er && (b != e);
          return;
        end
      end
      if (nrd >= mx) return;
    end
  endfunction

  task automatic run_case(input bit er, input bit md, input logic [7:0] e, input int mx,
                          input int busy_n, input bit glitch, input bit errinj, input bit restart);
    logic [7:0] fin, b;
    bit dn, err; logic [7:0] dat; int nrd, start_cyc, w;
    fin = er ? 8'hFF : (errinj ? (e ^ 8'h01) : e);
    for (int i = 0; i < 64; i++) begin
      if (i < busy_n) begin
        b = 8'($urandom);
        b[7] = er ? 1'b0 : ~e[7];
        b[6] = i[0];
        seq[i] = b;
      end else if (glitch && i == busy_n) begin
        b = 8'($urandom);
        b[7] = fin[7];
        seq[i] = b;
      end else seq[i] = fin;
    end
    predict(er, md, e, mx, dn, err, dat, nrd);
    @(negedge clk_i);
    idx = 0; first_cyc = -1; addr_bad = 0; req_drop = 0;
    cur_addr = 24'($urandom);
    op_erase_i = er; mode_toggle_i = md; exp_data_i = e;
    poll_addr_i = cur_addr; max_polls_i = 16'(mx);
    start_i = 1'b1; start_cyc = cyc;
    @(negedge clk_i);
    start_i = 1'b0;
    chk(busy_o === 1'b1, "R2 busy after start", busy_o, 1);
    if (restart) begin
      repeat (3) @(negedge clk_i);
      poll_addr_i = ~cur_addr; op_erase_i = ~er; start_i = 1'b1;
      @(negedge clk_i);
      start_i = 1'b0;
    end
    w = 0;
    while (!(done_o || timeout_o) && w < 3000) begin @(negedge clk_i); w++; end
    if (w >= 3000) chk(0, "watchdog", w, 0);
    repeat (4) @(negedge clk_i);
    chk(done_o == dn, dn ? "R8 done" : "R9 no done", done_o, dn);
    chk(timeout_o == !dn, "R9 timeout", timeout_o, !dn);
    chk(!(done_o && timeout_o), "R11 exclusive", {done_o, timeout_o}, 0);
    chk(idx == nrd, "R9 read count", idx, nrd);
    chk(busy_o == 1'b0 && rd_req_o == 1'b0, "R2 idle after end", {busy_o, rd_req_o}, 0);
    chk(addr_bad == 0, "R4 address", addr_bad, 0);
    chk(req_drop == 0, "R4 request held", req_drop, 0);
    chk(first_cyc - start_cyc > GAP, "R3 start gap", first_cyc - start_cyc, GAP + 1);
    if (dn) begin
      chk(data_o == dat, md ? "R7 data" : (er ? "R6 data" : "R5 data"), data_o, dat);
      chk(error_o == err, "R10 error", error_o, err);
    end else chk(error_o == 1'b0, "R10 no error on timeout", error_o, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    chk(busy_o === 0 && done_o === 0 && timeout_o === 0 && error_o === 0 && rd_req_o === 0,
        "R1 reset outputs", {busy_o, done_o, timeout_o, error_o, rd_req_o}, 0);
    chk(data_o === 8'h00, "R1 reset data", data_o, 0);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(busy_o === 0 && rd_req_o === 0, "R1 after release", {busy_o, rd_req_o}, 0);
    void'($urandom(32'h5EED));
    // directed corners
    lat_max = 0;
    run_case(0, 0, 8'hA5, 20, 3, 1, 0, 0);  // R5 transient byte then confirm
    run_case(1, 0, 8'h00, 20, 5, 0, 0, 0);  // R6 erase flag
    run_case(0, 1, 8'h3C, 20, 6, 1, 0, 0);  // R7 toggle with transient
    run_case(0, 0, 8'h81, 20, 2, 0, 1, 0);  // R10 mismatch on program
    run_case(1, 1, 8'h12, 20, 4, 0, 0, 0);  // R10 erase never errors
    run_case(0, 0, 8'h55, 5, 30, 0, 0, 0);  // R9 timeout at budget
    run_case(0, 0, 8'h55, 5, 4, 0, 0, 0);   // R9 completion on last budgeted read
    run_case(0, 1, 8'h55, 0, 10, 0, 0, 0);  // R9 zero budget
    run_case(0, 1, 8'hF0, 30, 8, 0, 0, 1);  // R2 restart while busy ignored
    lat_max = 3;
    for (int k = 0; k < 30; k++)
      run_case(1'($urandom), 1'($urandom), 8'($urandom), $urandom_range(0, 40),
               $urandom_range(0, 25), 1'($urandom), 1'($urandom), 1'($urandom));
    chk(done_o ^ timeout_o, "R11 flag held", {done_o, timeout_o}, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 190000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule